// File: doc/BRIEF.md
# Block Security Lookup Register Bank

This block is the software-facing configuration store of a block-granular security filter. Memory behind the filter is split into equal blocks of 2^BLK_LOG2 bytes. One lookup bit per block, packed into 32-bit lookup words, says whether that block belongs to the non-secure world (1) or the secure world (0). All lookup words are presented in parallel on `blk_lut` so that an external filter can decide on every transfer. That filter also reads the response mode on `resp_err`, and reports each refused transfer back on the `flt_*` inputs.

Software sees a 32-bit register bank with byte, halfword and word accesses. The lookup array is reached through a single window register, addressed by an index register that can step forward on its own after each full-word window access, wrapping at the number of lookup words. This lets a driver stream the whole table with back-to-back word accesses. A sticky lock bit freezes the control, window and interrupt-enable registers until the next reset. Only secure requesters may touch any register. The first refused transfer after status is clear records its address and attributes and raises status. The interrupt line is the AND of status and enable.

Top module: `secfilt_regbank`

## Requirements
- R1: After reset, control reads 0x00000100, index 0, status 0, enable 1, fault address 0, fault attributes 0, every lookup word 0 and `irq` is low.
- R2: In the control word at offset 0x00, only bit 4 (response mode, also driven on `resp_err`), bit 8 (index auto-step) and bit 31 (lock) are stored. All other bits read 0 and ignore writes.
- R3: Offset 0x10 reads the number of lookup words (LUT_WORDS), and offset 0x14 reads BLK_LOG2 minus 5.
- R4: A write to the index register at 0x18 stores the written value modulo LUT_WORDS.
- R5: The window at 0x1C reads and writes the lookup word selected by the index, and word k of the array appears on `blk_lut[32k+31:32k]`.
- R6: With control bit 8 set, every full-word (size code 2) read or accepted write of the window advances the index by one, wrapping from LUT_WORDS-1 to 0. Byte (code 0) and halfword (code 1) window accesses never advance it, and with bit 8 clear nothing advances it.
- R7: While control bit 31 is set, writes to control, window and enable (0x28) are ignored, and a refused window write does not advance the index. Only reset clears bit 31.
- R8: An access with `bus_secure` low to any offset below 0xFD0 reads as 0 and changes no state.
- R9: A sub-word write to control, index or window merges the written lanes into the current value. A sub-word write to any other register fills the unwritten lanes with zero.
- R10: Writing 1 to bit 0 of 0x34 sets status, and writing 1 to bit 0 of 0x24 clears it. Status reads at 0x20 bit 0, enable is at 0x28 bit 0, and `irq` is status AND enable.
- R11: A `flt_valid` pulse while status is 0 stores `flt_addr` in the fault address register (0x2C), stores {lookup bit of the faulting block at bit 17, `flt_nonsec` at bit 16, `flt_master` at bits 15:0} in the fault attribute register (0x30), and sets status. While status is 1, further faults change neither register.
- R12: Sub-word reads return the addressed byte lanes (starting at lane `bus_addr[1:0]`) right-aligned. Reads of 0x24, 0x34 and of undefined offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the register bank |
| bus_size | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| bus_wdata | input | 32 | Write data, right-aligned for sub-word writes |
| bus_secure | input | 1 | Requester is secure |
| bus_rdata | output | 32 | Read data, same cycle, right-aligned |
| flt_valid | input | 1 | The filter refused a transfer this cycle |
| flt_addr | input | 32 | Address of the refused transfer |
| flt_master | input | 16 | Requester identifier of the refused transfer |
| flt_nonsec | input | 1 | Refused transfer was non-secure |
| blk_lut | output | LUT_WORDS*32 | Whole lookup array, one bit per block |
| resp_err | output | 1 | Refused transfers get an error response |
| irq | output | 1 | Level interrupt |

## Verification
The checker watches, on every cycle, that the index stays below LUT_WORDS and that reserved control bits stay zero. It also watches that the lock bit never falls outside reset, that a non-secure access returns zero and leaves control, index and the lookup array untouched, that a set write raises status, and that the fault address holds while status is set. Byte-lane merging versus zero-filling, the wrap of the auto-stepping index, the exact fault attribute layout, the lookup bit picked for a fault address and the full reset state depend on data values and access order, so only the bench's scenarios can show them.

// File: rtl/secfilt_pkg.sv
// Package: register offsets, control bit positions and access size codes
// shared by the register bank, its submodules and its checker.
package secfilt_pkg;
    localparam logic [11:0] OFS_CTRL     = 12'h000;
    localparam logic [11:0] OFS_MAXIDX   = 12'h010;
    localparam logic [11:0] OFS_BLKCFG   = 12'h014;
    localparam logic [11:0] OFS_INDEX    = 12'h018;
    localparam logic [11:0] OFS_WINDOW   = 12'h01C;
    localparam logic [11:0] OFS_STAT     = 12'h020;
    localparam logic [11:0] OFS_CLR      = 12'h024;
    localparam logic [11:0] OFS_EN       = 12'h028;
    localparam logic [11:0] OFS_FADDR    = 12'h02C;
    localparam logic [11:0] OFS_FATTR    = 12'h030;
    localparam logic [11:0] OFS_SET      = 12'h034;
    localparam logic [11:0] OFS_NS_LIMIT = 12'hFD0;

    localparam int CTRL_RESP_BIT = 4;
    localparam int CTRL_STEP_BIT = 8;
    localparam int CTRL_LOCK_BIT = 31;
    localparam logic [31:0] CTRL_MASK  = 32'h8000_0110;
    localparam logic [31:0] CTRL_RESET = 32'h0000_0100;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;
endpackage

// File: rtl/secfilt_lane.sv
// Byte-lane helper: merges sub-word write data into a base word and
// extracts the addressed lanes of a read word, right-aligned.
// Assumes accesses are naturally aligned; size code 3 is taken as a word.
module secfilt_lane
    import secfilt_pkg::*;
(
    input  logic [1:0]  size,
    input  logic [1:0]  lane,
    input  logic [31:0] wdata,
    input  logic [31:0] base,
    input  logic [31:0] rword,
    output logic [31:0] merged,
    output logic [31:0] rext
);
    logic [4:0]  shamt;
    logic [31:0] lane_mask;
    logic [31:0] rshift;

    assign shamt = {lane, 3'b000};

    // Pick the lanes covered by this access.
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: lane_mask = 32'h0000_00FF << shamt;
            SZ_HALF: lane_mask = 32'h0000_FFFF << shamt;
            default: lane_mask = 32'hFFFF_FFFF;
        endcase
    end

    // Merge written lanes over the base word.
    assign merged = (base & ~lane_mask) | ((wdata << shamt) & lane_mask);

    // Right-align the addressed read lanes.
    assign rshift = rword >> shamt;
    always_comb begin
        case (acc_size_e'(size))
            SZ_BYTE: rext = {24'h0, rshift[7:0]};
            SZ_HALF: rext = {16'h0, rshift[15:0]};
            default: rext = rword;
        endcase
    end
endmodule

// File: rtl/secfilt_lut.sv
// Lookup array with its index register. Holds LUT_WORDS 32-bit words,
// one bit per block; the index selects the window word, takes modulo
// writes and steps with wrap. Also looks up the bit of a fault address.
// Assumes idx_wr and step are never high together (decoded from one access).
module secfilt_lut #(
    parameter int LUT_WORDS = 4,
    parameter int BLK_LOG2  = 12,
    parameter int IDX_W     = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   idx_wr,
    input  logic [31:0]            idx_wval,
    input  logic                   win_wr,
    input  logic [31:0]            win_wval,
    input  logic                   step,
    input  logic [31:0]            fault_addr,
    output logic [IDX_W-1:0]       cur_idx,
    output logic [31:0]            cur_word,
    output logic [LUT_WORDS*32-1:0] lut_flat,
    output logic                   fault_cfg
);
    localparam int NBITS  = LUT_WORDS * 32;
    localparam int FLAT_W = $clog2(NBITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LUT_WORDS - 1);

    logic [31:0] words [LUT_WORDS];
    logic [31:0] blk_num;

    // Lookup word storage, written through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LUT_WORDS; k++) words[k] <= '0;
        end else if (win_wr) begin
            words[cur_idx] <= win_wval;
        end
    end

    // Index register: modulo load or wrapping step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx <= '0;
        end else if (idx_wr) begin
            cur_idx <= IDX_W'(idx_wval % 32'(LUT_WORDS));
        end else if (step) begin
            cur_idx <= (cur_idx == LAST_IDX) ? '0 : cur_idx + IDX_W'(1);
        end
    end

    assign cur_word = words[cur_idx];

    // Flatten the array for the external filter.
    for (genvar g = 0; g < LUT_WORDS; g++) begin : g_flat
        assign lut_flat[g*32 +: 32] = words[g];
    end

    // Lookup bit of the block holding the fault address.
    assign blk_num   = fault_addr >> BLK_LOG2;
    assign fault_cfg = (blk_num < 32'(NBITS)) ? lut_flat[blk_num[FLAT_W-1:0]] : 1'b0;
endmodule

// File: rtl/secfilt_irq.sv
// Interrupt status, enable and fault capture. Status is set by software
// or by the first fault seen while clear; fault registers hold until
// status is cleared. irq is the level AND of status and enable.
module secfilt_irq (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        set_req,
    input  logic        clr_req,
    input  logic        en_wr,
    input  logic        en_wval,
    input  logic        flt_valid,
    input  logic [31:0] flt_addr,
    input  logic [15:0] flt_master,
    input  logic        flt_nonsec,
    input  logic        flt_cfg,
    output logic        stat_q,
    output logic        en_q,
    output logic [31:0] info1_q,
    output logic [31:0] info2_q,
    output logic        irq
);
    logic capture;

    assign capture = flt_valid && !stat_q;

    // Status bit update.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= 1'b0;
        else        stat_q <= (stat_q && !clr_req) || set_req || capture;
    end

    // Interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= 1'b1;
        else if (en_wr) en_q <= en_wval;
    end

    // Fault information capture on the first fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info1_q <= '0;
            info2_q <= '0;
        end else if (capture) begin
            info1_q <= flt_addr;
            info2_q <= {14'h0, flt_cfg, flt_nonsec, flt_master};
        end
    end

    assign irq = stat_q & en_q;
endmodule

// File: rtl/secfilt_regbank.sv
// Top: register bank of the block security filter. Decodes single-cycle
// register accesses (read data combinational, side effects at the edge),
// enforces secure-only access and lock, and holds the control word.
// Assumes one access per cycle and BLK_LOG2 >= 5.
module secfilt_regbank
    import secfilt_pkg::*;
#(
    parameter int LUT_WORDS = 4,
    parameter int BLK_LOG2  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [11:0]             bus_addr,
    input  logic [1:0]              bus_size,
    input  logic [31:0]             bus_wdata,
    input  logic                    bus_secure,
    output logic [31:0]             bus_rdata,
    input  logic                    flt_valid,
    input  logic [31:0]             flt_addr,
    input  logic [15:0]             flt_master,
    input  logic                    flt_nonsec,
    output logic [LUT_WORDS*32-1:0] blk_lut,
    output logic                    resp_err,
    output logic                    irq
);
    localparam int IDX_W = (LUT_WORDS > 1) ? $clog2(LUT_WORDS) : 1;
    localparam logic [31:0] MAXIDX_VAL = 32'(LUT_WORDS);
    localparam logic [31:0] BLKCFG_VAL = 32'(BLK_LOG2 - 5);

    logic [11:0]      ofs;
    logic             acc, wr, rd, full_word, locked;
    logic [31:0]      ctrl_q;
    logic [31:0]      base_word, wval, rword, rext;
    logic [IDX_W-1:0] cur_idx;
    logic [31:0]      cur_word;
    logic             fault_cfg;
    logic             stat_q, en_q;
    logic [31:0]      info1_q, info2_q;
    logic             idx_wr, win_wr, step, en_wr, set_req, clr_req;

    // Access qualification: secure only, below the limit offset.
    assign ofs       = {bus_addr[11:2], 2'b00};
    assign acc       = bus_valid && bus_secure && (bus_addr < OFS_NS_LIMIT);
    assign wr        = acc && bus_write;
    assign rd        = acc && !bus_write;
    assign full_word = bus_size[1];
    assign locked    = ctrl_q[CTRL_LOCK_BIT];

    // Base word for sub-word write merging; zero for fill registers.
    always_comb begin
        case (ofs)
            OFS_CTRL:   base_word = ctrl_q;
            OFS_INDEX:  base_word = 32'(cur_idx);
            OFS_WINDOW: base_word = cur_word;
            default:    base_word = '0;
        endcase
    end

    secfilt_lane i_lane (
        .size   (bus_size),
        .lane   (bus_addr[1:0]),
        .wdata  (bus_wdata),
        .base   (base_word),
        .rword  (rword),
        .merged (wval),
        .rext   (rext)
    );

    // Write strobes for the submodules.
    assign idx_wr  = wr && (ofs == OFS_INDEX);
    assign win_wr  = wr && (ofs == OFS_WINDOW) && !locked;
    assign en_wr   = wr && (ofs == OFS_EN) && !locked;
    assign set_req = wr && (ofs == OFS_SET) && wval[0];
    assign clr_req = wr && (ofs == OFS_CLR) && wval[0];
    assign step    = ctrl_q[CTRL_STEP_BIT] && full_word && (ofs == OFS_WINDOW)
                     && (rd || win_wr);

    // Control word, frozen by lock.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (wr && (ofs == OFS_CTRL) && !locked)
            ctrl_q <= wval & CTRL_MASK;
    end

    secfilt_lut #(
        .LUT_WORDS (LUT_WORDS),
        .BLK_LOG2  (BLK_LOG2),
        .IDX_W     (IDX_W)
    ) i_lut (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_wr     (idx_wr),
        .idx_wval   (wval),
        .win_wr     (win_wr),
        .win_wval   (wval),
        .step       (step),
        .fault_addr (flt_addr),
        .cur_idx    (cur_idx),
        .cur_word   (cur_word),
        .lut_flat   (blk_lut),
        .fault_cfg  (fault_cfg)
    );

    secfilt_irq i_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (set_req),
        .clr_req    (clr_req),
        .en_wr      (en_wr),
        .en_wval    (wval[0]),
        .flt_valid  (flt_valid),
        .flt_addr   (flt_addr),
        .flt_master (flt_master),
        .flt_nonsec (flt_nonsec),
        .flt_cfg    (fault_cfg),
        .stat_q     (stat_q),
        .en_q       (en_q),
        .info1_q    (info1_q),
        .info2_q    (info2_q),
        .irq        (irq)
    );

    // Full-word read multiplexer.
    always_comb begin
        case (ofs)
            OFS_CTRL:   rword = ctrl_q;
            OFS_MAXIDX: rword = MAXIDX_VAL;
            OFS_BLKCFG: rword = BLKCFG_VAL;
            OFS_INDEX:  rword = 32'(cur_idx);
            OFS_WINDOW: rword = cur_word;
            OFS_STAT:   rword = {31'h0, stat_q};
            OFS_EN:     rword = {31'h0, en_q};
            OFS_FADDR:  rword = info1_q;
            OFS_FATTR:  rword = info2_q;
            default:    rword = '0;
        endcase
    end

    assign bus_rdata = rd ? rext : '0;
    assign resp_err  = ctrl_q[CTRL_RESP_BIT];
endmodule

// File: rtl/secfilt_regbank_chk.sv
// Checker for secfilt_regbank, bound to every instance of the top.
module secfilt_regbank_chk
    import secfilt_pkg::*;
#(
    parameter int LUT_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_valid,
    input logic                    bus_write,
    input logic                    bus_secure,
    input logic [11:0]             bus_addr,
    input logic [1:0]              bus_size,
    input logic [31:0]             bus_wdata,
    input logic [31:0]             bus_rdata,
    input logic [31:0]             ctrl_q,
    input logic [IDX_W-1:0]        cur_idx,
    input logic [LUT_WORDS*32-1:0] blk_lut,
    input logic                    stat_q,
    input logic [31:0]             info1_q
);
    assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cur_idx) < 32'(LUT_WORDS));

    assert_ctrl_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == 32'h0);

    assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[CTRL_LOCK_BIT] |=> ctrl_q[CTRL_LOCK_BIT]);

    assert_ns_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !bus_secure) |-> (bus_rdata == 32'h0));

    assert_ns_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && !bus_secure)
        |=> ($stable(ctrl_q) && $stable(cur_idx) && $stable(blk_lut)));

    assert_set_raises_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_secure && bus_addr == OFS_SET
         && bus_size == 2'd2 && bus_wdata[0]) |=> stat_q);

    assert_fault_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q |=> $stable(info1_q));
endmodule

bind secfilt_regbank secfilt_regbank_chk #(
    .LUT_WORDS (LUT_WORDS),
    .IDX_W     (IDX_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_secure (bus_secure),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ctrl_q     (ctrl_q),
    .cur_idx    (cur_idx),
    .blk_lut    (blk_lut),
    .stat_q     (stat_q),
    .info1_q    (info1_q)
);

// File: tb/test_secfilt_regbank.sv
// Bench for secfilt_regbank: a vector table walked by one loop, then
// directed scenarios for lock, faults, interrupts and reset.
module test_secfilt_regbank;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0, bus_write = 1'b0, bus_secure = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [1:0]    bus_size = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          flt_valid = 1'b0, flt_nonsec = 1'b0;
    logic [31:0]   flt_addr = '0;
    logic [15:0]   flt_master = '0;
    logic [LW*32-1:0] blk_lut;
    logic          resp_err, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    secfilt_regbank #(.LUT_WORDS(LW), .BLK_LOG2(12)) i_secfilt_regbank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_secure(bus_secure), .bus_rdata(bus_rdata), .flt_valid(flt_valid),
        .flt_addr(flt_addr), .flt_master(flt_master), .flt_nonsec(flt_nonsec),
        .blk_lut(blk_lut), .resp_err(resp_err), .irq(irq)
    );

    // {wr, addr, size, wdata, secure, check, expected, requirement}
    localparam int NV = 40;
    localparam logic [84:0] VEC [NV] = '{
        {1'b0, 12'h000, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0100, 4'd1},  // R1
        {1'b0, 12'h010, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0004, 4'd3},  // R3
        {1'b0, 12'h014, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0007, 4'd3},  // R3
        {1'b0, 12'h028, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0001, 4'd1},  // R1
        {1'b0, 12'h018, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd1},  // R1
        {1'b1, 12'h000, 2'd2, 32'h0000_0FFF, 1'b1, 1'b0, 32'h0, 4'd2},
        {1'b0, 12'h000, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0110, 4'd2},  // R2
        {1'b1, 12'h01C, 2'd2, 32'hA5A5_0001, 1'b1, 1'b0, 32'h0, 4'd5},
        {1'b0, 12'h018, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0001, 4'd6},  // R6
        {1'b1, 12'h01C, 2'd2, 32'h0000_00F0, 1'b1, 1'b0, 32'h0, 4'd5},
        {1'b1, 12'h01C, 2'd2, 32'h0000_0003, 1'b1, 1'b0, 32'h0, 4'd5},
        {1'b1, 12'h01C, 2'd2, 32'h8000_0000, 1'b1, 1'b0, 32'h0, 4'd5},
        {1'b0, 12'h018, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd6},  // R6 wrap
        {1'b0, 12'h01C, 2'd2, 32'h0, 1'b1, 1'b1, 32'hA5A5_0001, 4'd5},  // R5
        {1'b0, 12'h01C, 2'd0, 32'h0, 1'b1, 1'b1, 32'h0000_00F0, 4'd12}, // R12
        {1'b0, 12'h018, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0001, 4'd6},  // R6 no step
        {1'b1, 12'h018, 2'd2, 32'h0000_0006, 1'b1, 1'b0, 32'h0, 4'd4},
        {1'b0, 12'h018, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0002, 4'd4},  // R4
        {1'b1, 12'h01D, 2'd0, 32'h0000_0055, 1'b1, 1'b0, 32'h0, 4'd9},
        {1'b0, 12'h018, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0002, 4'd6},  // R6
        {1'b0, 12'h01C, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_5503, 4'd9},  // R9
        {1'b0, 12'h01E, 2'd1, 32'h0, 1'b1, 1'b1, 32'h0000_8000, 4'd12}, // R12
        {1'b1, 12'h029, 2'd0, 32'h0000_00FF, 1'b1, 1'b0, 32'h0, 4'd9},
        {1'b0, 12'h028, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd9},  // R9 fill
        {1'b1, 12'h028, 2'd2, 32'h0000_0001, 1'b1, 1'b0, 32'h0, 4'd10},
        {1'b1, 12'h000, 2'd2, 32'h0000_0000, 1'b0, 1'b0, 32'h0, 4'd8},
        {1'b0, 12'h000, 2'd2, 32'h0, 1'b0, 1'b1, 32'h0000_0000, 4'd8},  // R8
        {1'b0, 12'h000, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0110, 4'd8},  // R8
        {1'b0, 12'h024, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd12}, // R12
        {1'b0, 12'h03C, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd12}, // R12
        {1'b1, 12'h034, 2'd2, 32'h0000_0001, 1'b1, 1'b0, 32'h0, 4'd10},
        {1'b0, 12'h020, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0001, 4'd10}, // R10
        {1'b1, 12'h024, 2'd2, 32'h0000_0001, 1'b1, 1'b0, 32'h0, 4'd10},
        {1'b0, 12'h020, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd10}, // R10
        {1'b1, 12'h000, 2'd0, 32'h0000_0000, 1'b1, 1'b0, 32'h0, 4'd9},
        {1'b0, 12'h000, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0100, 4'd9},  // R9 merge
        {1'b0, 12'h001, 2'd0, 32'h0, 1'b1, 1'b1, 32'h0000_0001, 4'd12}, // R12
        {1'b0, 12'h01C, 2'd2, 32'h0, 1'b1, 1'b1, 32'h8000_0000, 4'd5},  // R5
        {1'b0, 12'h018, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd6},  // R6
        {1'b0, 12'h00C, 2'd2, 32'h0, 1'b1, 1'b1, 32'h0000_0000, 4'd12}  // R12
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One register access: drive at the falling edge, sample read data mid-low phase.
    task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                          input logic [31:0] d, input logic sec, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_size = sz;
        bus_wdata = d; bus_secure = sec;
        #5 rd = bus_rdata;
        @(posedge clk);
        #1 bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic fault(input logic [31:0] a, input logic [15:0] m, input logic ns);
        @(negedge clk);
        flt_valid = 1'b1; flt_addr = a; flt_master = m; flt_nonsec = ns;
        @(posedge clk);
        #1 flt_valid = 1'b0;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hang counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        check("R1 lut word0 after reset", blk_lut[31:0], 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [84:0] v;
            v = VEC[i];
            access(v[84], v[83:72], v[71:70], v[69:38], v[37], r);
            if (v[36]) check($sformatf("R%0d vector %0d", v[3:0], i), r, v[35:4]);
        end

        // R5: flattened array matches the words written through the window.
        @(negedge clk);
        check("R5 lut word0", blk_lut[31:0],   32'hA5A5_0001);
        check("R5 lut word1", blk_lut[63:32],  32'h0000_00F0);
        check("R5 lut word2", blk_lut[95:64],  32'h0000_5503);
        check("R5 lut word3", blk_lut[127:96], 32'h8000_0000);

        // R2 and R6: response bit on resp_err, no stepping with bit 8 clear.
        access(1'b1, 12'h000, 2'd2, 32'h0000_0010, 1'b1, r);
        @(negedge clk);
        check("R2 resp_err", {31'h0, resp_err}, 32'h1);
        access(1'b1, 12'h01C, 2'd2, 32'hA5A5_0001, 1'b1, r);
        access(1'b0, 12'h018, 2'd2, 32'h0, 1'b1, r);
        check("R6 no step when disabled", r, 32'h0);

        // R8: non-secure window and set writes change nothing.
        access(1'b1, 12'h01C, 2'd2, 32'h0, 1'b0, r);
        access(1'b1, 12'h034, 2'd2, 32'h1, 1'b0, r);
        @(negedge clk);
        check("R8 lut kept", blk_lut[31:0], 32'hA5A5_0001);
        check("R8 irq kept low", {31'h0, irq}, 32'h0);

        // R10: irq follows status AND enable.
        access(1'b1, 12'h034, 2'd2, 32'h1, 1'b1, r);
        @(negedge clk);
        check("R10 irq on set", {31'h0, irq}, 32'h1);
        access(1'b1, 12'h028, 2'd2, 32'h0, 1'b1, r);
        @(negedge clk);
        check("R10 irq masked", {31'h0, irq}, 32'h0);
        access(1'b1, 12'h028, 2'd2, 32'h1, 1'b1, r);
        access(1'b1, 12'h024, 2'd2, 32'h1, 1'b1, r);
        @(negedge clk);
        check("R10 irq cleared", {31'h0, irq}, 32'h0);

        // R11: first fault captured, later ones ignored until clear.
        fault(32'h0000_0040, 16'h1234, 1'b1);
        @(negedge clk);
        check("R11 irq on fault", {31'h0, irq}, 32'h1);
        access(1'b0, 12'h02C, 2'd2, 32'h0, 1'b1, r);
        check("R11 fault address", r, 32'h0000_0040);
        access(1'b0, 12'h030, 2'd2, 32'h0, 1'b1, r);
        check("R11 fault attributes", r, 32'h0003_1234);
        fault(32'h0000_1000, 16'h0007, 1'b0);
        access(1'b0, 12'h02C, 2'd2, 32'h0, 1'b1, r);
        check("R11 second fault ignored", r, 32'h0000_0040);
        access(1'b1, 12'h024, 2'd2, 32'h1, 1'b1, r);
        fault(32'h0000_1000, 16'h0007, 1'b0);
        access(1'b0, 12'h02C, 2'd2, 32'h0, 1'b1, r);
        check("R11 recapture address", r, 32'h0000_1000);
        access(1'b0, 12'h030, 2'd2, 32'h0, 1'b1, r);
        check("R11 recapture attributes", r, 32'h0000_0007);

        // R7: lock freezes control, enable and window.
        access(1'b1, 12'h000, 2'd2, 32'h8000_0110, 1'b1, r);
        access(1'b1, 12'h000, 2'd2, 32'h0, 1'b1, r);
        access(1'b0, 12'h000, 2'd2, 32'h0, 1'b1, r);
        check("R7 control frozen", r, 32'h8000_0110);
        access(1'b1, 12'h028, 2'd2, 32'h0, 1'b1, r);
        access(1'b0, 12'h028, 2'd2, 32'h0, 1'b1, r);
        check("R7 enable frozen", r, 32'h1);
        access(1'b1, 12'h01C, 2'd2, 32'h0, 1'b1, r);
        access(1'b0, 12'h018, 2'd2, 32'h0, 1'b1, r);
        check("R7 refused write no step", r, 32'h0);
        access(1'b0, 12'h01C, 2'd2, 32'h0, 1'b1, r);
        check("R7 window frozen", r, 32'hA5A5_0001);

        // R1: reset restores every register.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1 rst_n = 1'b1;
        access(1'b0, 12'h000, 2'd2, 32'h0, 1'b1, r);
        check("R1 control after reset", r, 32'h0000_0100);
        access(1'b0, 12'h030, 2'd2, 32'h0, 1'b1, r);
        check("R1 fault attributes after reset", r, 32'h0);
        access(1'b0, 12'h02C, 2'd2, 32'h0, 1'b1, r);
        check("R1 fault address after reset", r, 32'h0);
        access(1'b0, 12'h020, 2'd2, 32'h0, 1'b1, r);
        check("R1 status after reset", r, 32'h0);
        @(negedge clk);
        check("R1 lut word0 cleared", blk_lut[31:0], 32'h0);
        check("R1 irq low", {31'h0, irq}, 32'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule